// File: doc/BRIEF.md
# Wide-Register Write Bridge

This block takes one wide register transfer from a processor core and turns it into a single memory write. A transfer can load the write address, carry the write data, or do both in one step. An accepted data transfer becomes one command beat (address and byte count) and one data beat (data and byte strobes) on a simple valid/ready master interface. A 4-entry command FIFO and a 4-entry data FIFO sit between the core side and the bus side.

The bridge keeps a 48-bit address register. A transfer may load all 48 bits or only the lower 32, and in the second case the upper 16 bits keep their earlier value. A mode bit selects a 32-byte line or a 64-byte line. Transfers that break the size or alignment rules are dropped, and a sticky error flag records that this happened. The busy output stays high as long as either FIFO holds anything.

Top module: `wrb_bridge`

## Requirements
- R1: Only transfers whose `xfer_id` is 0x62 or 0x63 have any effect, and both IDs behave the same. A transfer with any other ID issues no bus beat, leaves the address register unchanged and does not set the error flag.
- R2: With `xfer_addr_lo`=1 the low 32 address bits load from `xfer_addr`. They load together with the upper 16 bits when `xfer_addr_full`=1, and without them otherwise, in which case the upper 16 bits keep their value. The address persists across transfers. An address-only transfer issues no bus beat.
- R3: A transfer that carries both an address load and data is accepted only with size code 2 (full line). Any other size drops the whole transfer, including its address, and sets the error flag.
- R4: The `xfer_size` encoding is 0 = 1 byte, 1 = 4 bytes, 2 = full line, 3 = reserved (always dropped). In 32-byte mode (`cfg_wide`=0) the byte counts are 1, 4 and 32. The strobe sets exactly the lowest byte-count bits.
- R5: In 64-byte mode (`cfg_wide`=1) only size code 2 is accepted, with a byte count of 64, all 64 strobes set, and an address that is a multiple of 64.
- R6: A full-line write must have an address that is a multiple of the line size. A 4-byte write must have an address that is a multiple of 4 unless `cfg_unaligned`=1. A 1-byte write has no alignment rule.
- R7: A dropped transfer changes nothing except the error flag, which sets and stays set until reset.
- R8: `xfer_ready` is low while either FIFO holds 4 entries, and a transfer waits while it is low.
- R9: `wr_busy` is 1 while either FIFO is not empty and 0 when both are empty.
- R10: Each accepted data transfer produces one command beat and one data beat, in order. The data beat carries `xfer_data` unchanged, and a beat holds its values while it is stalled.
- R11: After reset, busy, error and both valids are 0, `xfer_ready` is 1 and the address register is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_valid | input | 1 | Transfer offered by the core |
| xfer_ready | output | 1 | Bridge can take a transfer |
| xfer_id | input | 8 | Port ID of the transfer |
| xfer_addr_lo | input | 1 | Transfer loads the low 32 address bits |
| xfer_addr_full | input | 1 | With xfer_addr_lo, also loads the upper 16 bits |
| xfer_has_data | input | 1 | Transfer carries write data |
| xfer_size | input | 2 | Size code of the data |
| xfer_addr | input | 48 | Address value |
| xfer_data | input | 512 | Write data, byte 0 in the low bits |
| cfg_wide | input | 1 | 1 = 64-byte line, 0 = 32-byte line |
| cfg_unaligned | input | 1 | Allow unaligned 4-byte writes |
| m_cmd_valid | output | 1 | Command beat valid |
| m_cmd_ready | input | 1 | Bus accepts the command beat |
| m_cmd_addr | output | 48 | Write address |
| m_cmd_bytes | output | 7 | Byte count |
| m_dat_valid | output | 1 | Data beat valid |
| m_dat_ready | input | 1 | Bus accepts the data beat |
| m_dat_data | output | 512 | Write data |
| m_dat_strb | output | 64 | Byte strobes |
| wr_busy | output | 1 | Either FIFO is occupied |
| wr_error | output | 1 | Sticky flag for a dropped transfer |

## Verification
If the address register is corrupt, the error shows at the port on the next accepted data transfer. The command beat then carries the wrong address in the cycle after acceptance, even when that transfer loaded no address itself. If a FIFO pointer or count is wrong, the fault shows the same cycle as a beat that repeats or goes missing, or as a wrong value on `wr_busy` or `xfer_ready`. A wrong legality decision shows one cycle after the offer: a beat appears that should not, or none appears when one should, and `wr_error` is wrong from then on.

// File: rtl/wrb_pkg.sv
package wrb_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LINE = 2'd2,
        SZ_RSVD = 2'd3
    } wr_size_e;
endpackage

// File: rtl/wrb_fifo.sv
module wrb_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             full,
    output logic             empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PW-1:0] wp;
        logic [PW-1:0] rp;
        logic [CW-1:0] cnt;
    } ptr_t;

    ptr_t st_d, st_q;
    logic [WIDTH-1:0] mem_q [DEPTH];

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full  = (st_q.cnt == CW'(DEPTH));
    assign empty = (st_q.cnt == '0);
    assign dout  = mem_q[st_q.rp];

    always_comb begin
        st_d = st_q;
        if (push) st_d.wp = bump(st_q.wp);
        if (pop)  st_d.rp = bump(st_q.rp);
        case ({push, pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push) mem_q[st_q.wp] <= din;
    end
endmodule

// File: rtl/wrb_check.sv
module wrb_check
    import wrb_pkg::*;
#(
    parameter int LINE_MAX = 64
) (
    input  wr_size_e                         size,
    input  logic                             wide,
    input  logic                             unal_en,
    input  logic                             with_addr,
    input  logic [$clog2(LINE_MAX)-1:0]      addr_off,
    output logic                             legal,
    output logic [$clog2(LINE_MAX+1)-1:0]    nbytes,
    output logic [LINE_MAX-1:0]              strb
);
    localparam int OW = $clog2(LINE_MAX);
    localparam int CW = $clog2(LINE_MAX + 1);

    logic [CW-1:0] line_bytes;
    logic [OW-1:0] line_mask;

    always_comb begin
        line_bytes = wide ? CW'(LINE_MAX) : CW'(LINE_MAX / 2);
        line_mask  = OW'(line_bytes - 1'b1);
        legal      = 1'b0;
        nbytes     = '0;
        case (size)
            SZ_BYTE: begin
                nbytes = CW'(1);
                legal  = !wide;
            end
            SZ_WORD: begin
                nbytes = CW'(4);
                legal  = !wide && (unal_en || (addr_off[1:0] == 2'b00));
            end
            SZ_LINE: begin
                nbytes = line_bytes;
                legal  = ((addr_off & line_mask) == '0);
            end
            default: begin
                nbytes = '0;
                legal  = 1'b0;
            end
        endcase
        if (with_addr && (size != SZ_LINE)) legal = 1'b0;
    end

    for (genvar i = 0; i < LINE_MAX; i++) begin : g_strb
        assign strb[i] = (CW'(i) < nbytes);
    end
endmodule

// File: rtl/wrb_bridge.sv
module wrb_bridge
    import wrb_pkg::*;
#(
    parameter int          ADDR_W   = 48,
    parameter int          LO_W     = 32,
    parameter int          LINE_MAX = 64,
    parameter int          DEPTH    = 4,
    parameter int          ID_W     = 8,
    parameter logic [7:0]  PORT_A   = 8'h62,
    parameter logic [7:0]  PORT_B   = 8'h63
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           xfer_valid,
    output logic                           xfer_ready,
    input  logic [ID_W-1:0]                xfer_id,
    input  logic                           xfer_addr_lo,
    input  logic                           xfer_addr_full,
    input  logic                           xfer_has_data,
    input  logic [1:0]                     xfer_size,
    input  logic [ADDR_W-1:0]              xfer_addr,
    input  logic [LINE_MAX*8-1:0]          xfer_data,
    input  logic                           cfg_wide,
    input  logic                           cfg_unaligned,
    output logic                           m_cmd_valid,
    input  logic                           m_cmd_ready,
    output logic [ADDR_W-1:0]              m_cmd_addr,
    output logic [$clog2(LINE_MAX+1)-1:0]  m_cmd_bytes,
    output logic                           m_dat_valid,
    input  logic                           m_dat_ready,
    output logic [LINE_MAX*8-1:0]          m_dat_data,
    output logic [LINE_MAX-1:0]            m_dat_strb,
    output logic                           wr_busy,
    output logic                           wr_error
);
    localparam int DATA_W = LINE_MAX * 8;
    localparam int CNT_W  = $clog2(LINE_MAX + 1);
    localparam int OFF_W  = $clog2(LINE_MAX);
    localparam int HI_W   = ADDR_W - LO_W;
    localparam int CMD_W  = ADDR_W + CNT_W;
    localparam int DAT_W  = DATA_W + LINE_MAX;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              err;
    } regs_t;

    regs_t r_d, r_q;

    logic              id_hit, fire, push;
    logic              chk_legal;
    logic [CNT_W-1:0]  chk_bytes;
    logic [LINE_MAX-1:0] chk_strb;
    logic [ADDR_W-1:0] addr_next;
    logic              cmd_full, cmd_empty, dat_full, dat_empty;
    logic [CMD_W-1:0]  cmd_out;
    logic [DAT_W-1:0]  dat_out;

    assign id_hit     = (xfer_id == ID_W'(PORT_A)) || (xfer_id == ID_W'(PORT_B));
    assign xfer_ready = !cmd_full && !dat_full;
    assign fire       = xfer_valid && xfer_ready && id_hit;

    always_comb begin
        addr_next = r_q.addr;
        if (xfer_addr_lo) begin
            addr_next[LO_W-1:0] = xfer_addr[LO_W-1:0];
            if (xfer_addr_full) addr_next[ADDR_W-1:LO_W] = xfer_addr[ADDR_W-1:LO_W];
        end
    end

    wrb_check #(.LINE_MAX(LINE_MAX)) u_check (
        .size      (wr_size_e'(xfer_size)),
        .wide      (cfg_wide),
        .unal_en   (cfg_unaligned),
        .with_addr (xfer_addr_lo),
        .addr_off  (addr_next[OFF_W-1:0]),
        .legal     (chk_legal),
        .nbytes    (chk_bytes),
        .strb      (chk_strb)
    );

    assign push = fire && xfer_has_data && chk_legal;

    always_comb begin
        r_d = r_q;
        if (fire) begin
            if (!xfer_has_data || chk_legal) r_d.addr = addr_next;
            else                             r_d.err  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    wrb_fifo #(.WIDTH(CMD_W), .DEPTH(DEPTH)) u_cmd_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .din   ({addr_next, chk_bytes}),
        .pop   (m_cmd_valid && m_cmd_ready),
        .dout  (cmd_out),
        .full  (cmd_full),
        .empty (cmd_empty)
    );

    wrb_fifo #(.WIDTH(DAT_W), .DEPTH(DEPTH)) u_dat_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .din   ({xfer_data, chk_strb}),
        .pop   (m_dat_valid && m_dat_ready),
        .dout  (dat_out),
        .full  (dat_full),
        .empty (dat_empty)
    );

    assign m_cmd_valid = !cmd_empty;
    assign m_cmd_addr  = cmd_out[CMD_W-1:CNT_W];
    assign m_cmd_bytes = cmd_out[CNT_W-1:0];
    assign m_dat_valid = !dat_empty;
    assign m_dat_data  = dat_out[DAT_W-1:LINE_MAX];
    assign m_dat_strb  = dat_out[LINE_MAX-1:0];
    assign wr_busy     = !cmd_empty || !dat_empty;
    assign wr_error    = r_q.err;

    logic unused_hi;
    assign unused_hi = ^{HI_W{1'b0}};
endmodule

// File: rtl/wrb_bridge_chk.sv
module wrb_bridge_chk #(
    parameter int ADDR_W   = 48,
    parameter int LINE_MAX = 64
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           xfer_ready,
    input logic                           m_cmd_valid,
    input logic                           m_cmd_ready,
    input logic [ADDR_W-1:0]              m_cmd_addr,
    input logic [$clog2(LINE_MAX+1)-1:0]  m_cmd_bytes,
    input logic                           m_dat_valid,
    input logic                           m_dat_ready,
    input logic [LINE_MAX-1:0]            m_dat_strb,
    input logic                           wr_busy,
    input logic                           wr_error
);
    localparam int CNT_W = $clog2(LINE_MAX + 1);
    localparam int OFF_W = $clog2(LINE_MAX);

    AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (m_cmd_valid && !m_cmd_ready) |=> (m_cmd_valid && $stable(m_cmd_addr) && $stable(m_cmd_bytes))); // R10

    AST_DAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (m_dat_valid && !m_dat_ready) |=> (m_dat_valid && $stable(m_dat_strb))); // R10

    AST_IDLE_NO_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_busy |-> (!m_cmd_valid && !m_dat_valid)); // R9

    AST_IDLE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_busy |-> xfer_ready); // R8

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        wr_error |=> wr_error); // R7

    AST_STRB_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
        m_dat_valid |-> ($countones(m_dat_strb) == 1 || $countones(m_dat_strb) == 4 ||
                         $countones(m_dat_strb) == LINE_MAX / 2 || $countones(m_dat_strb) == LINE_MAX)); // R4

    AST_WIDE_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (m_cmd_valid && m_cmd_bytes == CNT_W'(LINE_MAX)) |-> (m_cmd_addr[OFF_W-1:0] == '0)); // R5

    AST_HALF_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (m_cmd_valid && m_cmd_bytes == CNT_W'(LINE_MAX / 2)) |-> (m_cmd_addr[OFF_W-2:0] == '0)); // R6
endmodule

bind wrb_bridge wrb_bridge_chk #(.ADDR_W(ADDR_W), .LINE_MAX(LINE_MAX)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .xfer_ready  (xfer_ready),
    .m_cmd_valid (m_cmd_valid),
    .m_cmd_ready (m_cmd_ready),
    .m_cmd_addr  (m_cmd_addr),
    .m_cmd_bytes (m_cmd_bytes),
    .m_dat_valid (m_dat_valid),
    .m_dat_ready (m_dat_ready),
    .m_dat_strb  (m_dat_strb),
    .wr_busy     (wr_busy),
    .wr_error    (wr_error)
);

// File: tb/sim_wrb_bridge.sv
module sim_wrb_bridge;
    localparam int CLK_P = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         xfer_valid = 1'b0, xfer_ready;
    logic [7:0]   xfer_id = 8'h00;
    logic         xfer_addr_lo = 1'b0, xfer_addr_full = 1'b0, xfer_has_data = 1'b0;
    logic [1:0]   xfer_size = 2'd0;
    logic [47:0]  xfer_addr = '0;
    logic [511:0] xfer_data = '0;
    logic         cfg_wide = 1'b0, cfg_unaligned = 1'b0;
    logic         m_cmd_valid, m_cmd_ready = 1'b0;
    logic [47:0]  m_cmd_addr;
    logic [6:0]   m_cmd_bytes;
    logic         m_dat_valid, m_dat_ready = 1'b0;
    logic [511:0] m_dat_data;
    logic [63:0]  m_dat_strb;
    logic         wr_busy, wr_error;

    int checks = 0;
    int errors = 0;
    int rmode  = 2;   // 0 random, 1 always ready, 2 stalled

    always #(CLK_P/2) clk = ~clk;

    wrb_bridge u0 (.*);

    task automatic chk(input string tag, input logic [511:0] act, input logic [511:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    typedef struct { logic [47:0] a; int n; } rcmd_t;
    typedef struct { logic [511:0] d; logic [63:0] s; } rdat_t;
    rcmd_t cq[$];
    rdat_t dq[$];
    logic [47:0] ref_addr;
    bit          ref_err;

    function automatic bit rule(input logic [1:0] sz, input bit wide, input bit unal,
                                input bit lo, input logic [47:0] a, output int n);
        int line = wide ? 64 : 32;
        n = 0;
        if (sz == 2'd2) begin n = line; return (a % line) == 0; end
        if (sz == 2'd3 || lo || wide) return 0;
        if (sz == 2'd0) begin n = 1; return 1; end
        n = 4;
        return unal || (a[1:0] == 2'b00);
    endfunction

    function automatic logic [63:0] mk_strb(input int n);
        logic [63:0] s = '0;
        for (int i = 0; i < n; i++) s[i] = 1'b1;
        return s;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            cq.delete(); dq.delete(); ref_addr = '0; ref_err = 0;
        end else begin
            bit rdy;
            bit ok;
            int n;
            logic [47:0] na;
            rdy = (cq.size() < 4) && (dq.size() < 4);
            if (cq.size() > 0 && m_cmd_ready) void'(cq.pop_front());
            if (dq.size() > 0 && m_dat_ready) void'(dq.pop_front());
            if (xfer_valid && rdy && (xfer_id == 8'h62 || xfer_id == 8'h63)) begin
                na = ref_addr;
                if (xfer_addr_lo) begin
                    na[31:0] = xfer_addr[31:0];
                    if (xfer_addr_full) na[47:32] = xfer_addr[47:32];
                end
                if (!xfer_has_data) ref_addr = na;
                else begin
                    ok = rule(xfer_size, cfg_wide, cfg_unaligned, xfer_addr_lo, na, n);
                    if (ok) begin
                        ref_addr = na;
                        cq.push_back('{na, n});
                        dq.push_back('{xfer_data, mk_strb(n)});
                    end else ref_err = 1;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk("R10 cmd valid", 512'(m_cmd_valid), 512'(cq.size() != 0));
            if (cq.size() != 0) begin
                chk("R10 cmd addr", 512'(m_cmd_addr), 512'(cq[0].a));
                chk("R4 cmd bytes", 512'(m_cmd_bytes), 512'(cq[0].n));
            end
            chk("R10 dat valid", 512'(m_dat_valid), 512'(dq.size() != 0));
            if (dq.size() != 0) begin
                chk("R10 dat data", m_dat_data, dq[0].d);
                chk("R4 dat strb", 512'(m_dat_strb), 512'(dq[0].s));
            end
            chk("R9 busy", 512'(wr_busy), 512'(cq.size() != 0 || dq.size() != 0));
            chk("R7 error", 512'(wr_error), 512'(ref_err));
            chk("R8 ready", 512'(xfer_ready), 512'(cq.size() < 4 && dq.size() < 4));
        end
    end

    // ---------------- bus-side ready driver ----------------
    initial begin
        forever begin
            @(negedge clk);
            case (rmode)
                0: begin m_cmd_ready = 1'($urandom % 2); m_dat_ready = 1'($urandom % 2); end
                1: begin m_cmd_ready = 1'b1; m_dat_ready = 1'b1; end
                default: begin m_cmd_ready = 1'b0; m_dat_ready = 1'b0; end
            endcase
        end
    end

    // Drives at a negedge, returns at the negedge after acceptance.
    task automatic send(input logic [7:0] id, input bit lo, input bit full, input bit dat,
                        input logic [1:0] sz, input logic [47:0] a, input logic [511:0] d,
                        input bit wide, input bit unal);
        xfer_valid = 1'b1; xfer_id = id; xfer_addr_lo = lo; xfer_addr_full = full;
        xfer_has_data = dat; xfer_size = sz; xfer_addr = a; xfer_data = d;
        cfg_wide = wide; cfg_unaligned = unal;
        while (!xfer_ready) @(negedge clk);
        @(negedge clk);
        xfer_valid = 1'b0;
    endtask

    task automatic drain_then_stall();
        rmode = 1;
        @(negedge clk);
        while (cq.size() != 0 || dq.size() != 0) @(negedge clk);
        rmode = 2;
        @(negedge clk);
        @(negedge clk);
    endtask

    logic [511:0] pat;

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 busy", 512'(wr_busy), 512'(0));
        chk("R11 error", 512'(wr_error), 512'(0));
        chk("R11 cmd valid", 512'(m_cmd_valid), 512'(0));
        chk("R11 ready", 512'(xfer_ready), 512'(1));
        rst_n = 1'b1;
        @(negedge clk);
        drain_then_stall();

        // R11 address is zero: data-only byte write goes to 0
        send(8'h62, 0, 0, 1, 2'd0, '0, 512'h5A, 0, 0);
        chk("R11 addr after reset", 512'(m_cmd_addr), 512'(0));
        drain_then_stall();

        // R2 full load, then low-only load keeps upper 16 bits
        send(8'h62, 1, 1, 0, 2'd0, 48'h1234_0000_0040, '0, 0, 0);
        chk("R2 addr-only no beat", 512'(wr_busy), 512'(0));
        pat = {16{32'hC0DE_0001}};
        send(8'h63, 1, 0, 1, 2'd2, 48'hFFFF_8000_0020, pat, 0, 0);
        chk("R2 sticky upper", 512'(m_cmd_addr), 512'(48'h1234_8000_0020));
        chk("R4 line32 bytes", 512'(m_cmd_bytes), 512'(32));
        chk("R4 line32 strb", 512'(m_dat_strb), 512'(64'h0000_0000_FFFF_FFFF));
        chk("R10 data intact", m_dat_data, pat);
        drain_then_stall();

        // R1 foreign ID ignored
        send(8'h61, 1, 1, 1, 2'd2, 48'hAAAA_AAAA_AA00, pat, 0, 0);
        chk("R1 no beat", 512'(wr_busy), 512'(0));
        chk("R1 no error", 512'(wr_error), 512'(0));
        send(8'h63, 0, 0, 1, 2'd0, '0, 512'h77, 0, 0);
        chk("R1 addr unchanged", 512'(m_cmd_addr), 512'(48'h1234_8000_0020));
        chk("R4 byte count", 512'(m_cmd_bytes), 512'(1));
        chk("R4 byte strb", 512'(m_dat_strb), 512'(64'h1));
        drain_then_stall();

        // R3 addr+data with partial size dropped
        send(8'h62, 1, 0, 1, 2'd1, 48'h0000_0000_0100, pat, 0, 0);
        chk("R3 dropped", 512'(wr_busy), 512'(0));
        chk("R3 error set", 512'(wr_error), 512'(1));
        send(8'h62, 0, 0, 1, 2'd1, '0, pat, 0, 0);
        chk("R3 addr not loaded", 512'(m_cmd_addr), 512'(48'h1234_8000_0020));
        chk("R4 word count", 512'(m_cmd_bytes), 512'(4));
        drain_then_stall();

        // R6 alignment of 4-byte and line writes
        send(8'h62, 1, 0, 0, 2'd0, 48'h0000_8000_0022, '0, 0, 0);
        send(8'h62, 0, 0, 1, 2'd1, '0, pat, 0, 0);
        chk("R6 unaligned word dropped", 512'(wr_busy), 512'(0));
        send(8'h62, 0, 0, 1, 2'd1, '0, pat, 0, 1);
        chk("R6 unaligned word allowed", 512'(m_cmd_addr), 512'(48'h1234_8000_0022));
        drain_then_stall();
        send(8'h62, 0, 0, 1, 2'd2, '0, pat, 0, 1);
        chk("R6 misaligned line dropped", 512'(wr_busy), 512'(0));
        send(8'h62, 0, 0, 1, 2'd3, '0, pat, 0, 1);
        chk("R4 reserved dropped", 512'(wr_busy), 512'(0));

        // R5 64-byte mode
        pat = {16{32'h6464_0000}} ^ {8{64'h0123_4567_89AB_CDEF}};
        send(8'h63, 1, 0, 1, 2'd2, 48'h0000_0000_0040, pat, 1, 0);
        chk("R5 wide addr", 512'(m_cmd_addr), 512'(48'h1234_0000_0040));
        chk("R5 wide bytes", 512'(m_cmd_bytes), 512'(64));
        chk("R5 wide strb", 512'(m_dat_strb), 512'({64{1'b1}}));
        chk("R10 wide data", m_dat_data, pat);
        drain_then_stall();
        send(8'h63, 0, 0, 1, 2'd1, '0, pat, 1, 1);
        chk("R5 word in wide dropped", 512'(wr_busy), 512'(0));
        send(8'h63, 1, 0, 1, 2'd2, 48'h0000_0000_0020, pat, 1, 0);
        chk("R5 misaligned wide dropped", 512'(wr_busy), 512'(0));
        send(8'h63, 0, 0, 1, 2'd2, '0, pat, 1, 0);
        chk("R5 addr kept", 512'(m_cmd_addr), 512'(48'h1234_0000_0040));
        drain_then_stall();

        // R8 FIFO full back-pressure
        for (int i = 0; i < 4; i++) send(8'h62, 0, 0, 1, 2'd0, '0, 512'(i), 0, 0);
        chk("R8 ready low when full", 512'(xfer_ready), 512'(0));
        chk("R9 busy when full", 512'(wr_busy), 512'(1));
        rmode = 1;
        @(negedge clk); @(negedge clk);
        chk("R8 ready back", 512'(xfer_ready), 512'(1));
        chk("R7 error sticky", 512'(wr_error), 512'(1));

        // random phase, model compared every cycle
        rmode = 0;
        for (int i = 0; i < 400; i++) begin
            logic [47:0] a;
            a = {16'($urandom), 32'($urandom)};
            case ($urandom % 4)
                0: a[5:0] = 6'd0;
                1: a[4:0] = 5'd0;
                2: a[1:0] = 2'd0;
                default: ;
            endcase
            send(($urandom % 5 == 0) ? 8'h60 : (($urandom % 2) ? 8'h62 : 8'h63),
                 1'($urandom % 3 == 0), 1'($urandom % 2), 1'($urandom % 5 != 0),
                 2'($urandom), a, {16{32'($urandom)}}, 1'($urandom % 3 == 0), 1'($urandom % 2));
            if ($urandom % 4 == 0) @(negedge clk);
        end
        rmode = 1;
        repeat (12) @(negedge clk);
        chk("R9 idle at end", 512'(wr_busy), 512'(0));

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual running expected done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule